// File: doc/BRIEF.md
# Nested Exception Fault Escalator

This block sits in the exception path of a processor core and decides what happens when a new exception is raised while an earlier one is still being delivered. It keeps a record of the last exception that matters for escalation. Each new request is classified against that record. The block then either passes the new vector through, promotes it to a double fault (vector 8, error code 0), or raises a sticky shutdown request on a triple fault.

Software interrupts raised by an interrupt instruction skip the escalation check entirely. They carry an instruction-length addend, which is added to the current instruction pointer to form the return address. When the core finishes delivering an exception, it pulses a delivery-complete strobe, and the stored record returns to "nothing pending". Requests and results each use a valid/ready handshake. A result is registered and appears in the cycle after the request is accepted.

Top module: `exc_escalator`

## Requirements
- R1: Vector classes are: contributory for vectors 0, 10, 11, 12 and 13; page fault for vector 14; double fault for vector 8; benign for every other value. A stored vector 0 is a genuine contributory record. It is not the empty state, which is tracked separately.
- R2: If the stored record is contributory and a new non-software exception is contributory, the result is vector 8 with error code 0.
- R3: If the stored record is vector 14 and a new non-software exception is contributory or vector 14, the result is vector 8 with error code 0.
- R4: In every other non-shutdown case, the result carries the requested vector and error code unchanged. This includes an empty record, a benign new vector, and a benign stored record.
- R5: If the stored record is vector 8 and a new non-software exception is accepted, no result is produced and `shutdown` rises one cycle later. `shutdown` then stays high and `req_ready` stays low until reset.
- R6: The record is overwritten with the final result vector only when that vector is contributory, 14 or 8. A benign result leaves the record as it was.
- R7: A software interrupt (`req_swint`=1) passes its vector and error code unchanged, never causes shutdown, and leaves the record untouched. Its `out_next_ip` is `req_ip + req_ilen`. For any other request, `out_next_ip` equals `req_ip`.
- R8: A `done` pulse empties the record. If a request is accepted in the same cycle, the clear takes effect first. The request is classified against an empty record, and its own record update is kept.
- R9: A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high only when `shutdown` is low and the output register is empty or being drained. `out_valid` rises in the cycle after acceptance, and the result holds stable while `out_ready` is low.
- R10: After reset, `out_valid` and `shutdown` are low, `req_ready` is high, and the record is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New exception or interrupt request |
| req_ready | output | 1 | Block can accept a request |
| req_vector | input | VEC_W | Requested vector number |
| req_swint | input | 1 | Request comes from a software interrupt instruction |
| req_errcode | input | ERR_W | Requested error code |
| req_ip | input | IP_W | Current instruction pointer |
| req_ilen | input | LEN_W | Instruction length, applied to software interrupts only |
| done | input | 1 | Delivery-complete strobe; empties the record |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_vector | output | VEC_W | Final vector |
| out_errcode | output | ERR_W | Final error code |
| out_next_ip | output | IP_W | Return address to deliver |
| out_swint | output | 1 | Result is a software interrupt |
| shutdown | output | 1 | Triple-fault shutdown request, sticky until reset |

## Verification
Two events can land in the same clock edge: the delivery-complete clear of the record, and the acceptance of a new request that would otherwise escalate against that record. The bench provokes this by storing a contributory vector and then raising another contributory vector with `done` pulsed in the same cycle. It then checks that the new vector passes through rather than becoming a double fault. A follow-up contributory request must promote to vector 8, which shows that the new vector, and not the empty state, was left in the record. A full sweep of every ordered pair of vectors 0 to 31 checks the escalation matrix against a model written in the bench.

// File: rtl/exc_esc_pkg.sv
// Package: shared class encoding and fixed vector numbers for the
// exception escalator. Vector numbers are architectural and fixed.
package exc_esc_pkg;

    // Escalation class of one vector
    typedef enum logic [1:0] {
        CLS_BENIGN  = 2'd0,
        CLS_CONTRIB = 2'd1,
        CLS_PAGE    = 2'd2,
        CLS_DOUBLE  = 2'd3
    } exc_class_e;

    localparam int VEC_DOUBLE_FAULT = 8;
    localparam int VEC_PAGE_FAULT   = 14;
    localparam int VEC_DIVIDE       = 0;
    localparam int VEC_CONTRIB_LO   = 10;
    localparam int VEC_CONTRIB_HI   = 13;

endpackage

// File: rtl/exc_vec_classify.sv
// Module: exc_vec_classify
// Maps a vector number to its escalation class (R1).
// Assumes VEC_W is at least 4 so every fixed vector number fits.
module exc_vec_classify
    import exc_esc_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] vec,
    output exc_class_e       cls
);

    localparam logic [VEC_W-1:0] V_DE = VEC_W'(VEC_DIVIDE);
    localparam logic [VEC_W-1:0] V_LO = VEC_W'(VEC_CONTRIB_LO);
    localparam logic [VEC_W-1:0] V_HI = VEC_W'(VEC_CONTRIB_HI);
    localparam logic [VEC_W-1:0] V_PF = VEC_W'(VEC_PAGE_FAULT);
    localparam logic [VEC_W-1:0] V_DF = VEC_W'(VEC_DOUBLE_FAULT);

    // Purpose: pick the class of the incoming vector
    always_comb begin
        if (vec == V_DE || (vec >= V_LO && vec <= V_HI)) begin
            cls = CLS_CONTRIB;
        end else if (vec == V_PF) begin
            cls = CLS_PAGE;
        end else if (vec == V_DF) begin
            cls = CLS_DOUBLE;
        end else begin
            cls = CLS_BENIGN;
        end
    end

endmodule

// File: rtl/exc_escalate_core.sv
// Module: exc_escalate_core
// Combinational decision: given the record and a new request, decide
// triple fault, promotion to double fault, or pass-through, and whether
// the record must be rewritten (R2..R7).
// Assumes the caller has already applied any same-cycle clear to
// prev_valid.
module exc_escalate_core
    import exc_esc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int ERR_W = 32
) (
    input  logic             prev_valid,
    input  logic [VEC_W-1:0] prev_vec,
    input  logic [VEC_W-1:0] new_vec,
    input  logic [ERR_W-1:0] new_err,
    input  logic             swint,
    output logic             triple,
    output logic             promote,
    output logic [VEC_W-1:0] fin_vec,
    output logic [ERR_W-1:0] fin_err,
    output logic             store_en
);

    localparam logic [VEC_W-1:0] V_DF = VEC_W'(VEC_DOUBLE_FAULT);

    exc_class_e prev_cls;
    exc_class_e new_cls;
    exc_class_e fin_cls;

    exc_vec_classify #(.VEC_W(VEC_W)) u_cls_prev (.vec(prev_vec), .cls(prev_cls));
    exc_vec_classify #(.VEC_W(VEC_W)) u_cls_new  (.vec(new_vec),  .cls(new_cls));
    exc_vec_classify #(.VEC_W(VEC_W)) u_cls_fin  (.vec(fin_vec),  .cls(fin_cls));

    logic prev_is_contrib;
    logic prev_is_page;
    logic prev_is_double;
    logic new_is_contrib;
    logic new_is_page;

    // Purpose: qualify the class flags with the record's valid bit
    always_comb begin
        prev_is_contrib = prev_valid && (prev_cls == CLS_CONTRIB);
        prev_is_page    = prev_valid && (prev_cls == CLS_PAGE);
        prev_is_double  = prev_valid && (prev_cls == CLS_DOUBLE);
        new_is_contrib  = (new_cls == CLS_CONTRIB);
        new_is_page     = (new_cls == CLS_PAGE);
    end

    // Purpose: escalation matrix, software interrupts bypass it
    always_comb begin
        triple  = !swint && prev_is_double;
        promote = !swint && !prev_is_double &&
                  ((prev_is_contrib && new_is_contrib) ||
                   (prev_is_page && (new_is_contrib || new_is_page)));
    end

    // Purpose: form the result vector and error code
    always_comb begin
        if (promote) begin
            fin_vec = V_DF;
            fin_err = '0;
        end else begin
            fin_vec = new_vec;
            fin_err = new_err;
        end
    end

    // Purpose: only non-benign results of real exceptions update the record
    always_comb begin
        store_en = !swint && !triple && (fin_cls != CLS_BENIGN);
    end

endmodule

// File: rtl/exc_prev_track.sv
// Module: exc_prev_track
// Holds the record of the last non-benign exception. A load in the same
// cycle as a clear wins, since the load already saw the cleared state
// (R6, R8, R10).
module exc_prev_track #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [VEC_W-1:0] load_vec,
    output logic             prev_valid,
    output logic [VEC_W-1:0] prev_vec
);

    // Purpose: update or empty the record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_vec   <= '0;
        end else if (load) begin
            prev_valid <= 1'b1;
            prev_vec   <= load_vec;
        end else if (clear) begin
            prev_valid <= 1'b0;
        end
    end

    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !load) |=> !prev_valid);

    a_r6_load_records: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (prev_valid && prev_vec == $past(load_vec)));

    a_r6_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load) |=> ($stable(prev_valid) && $stable(prev_vec)));

endmodule

// File: rtl/exc_escalator.sv
// Module: exc_escalator (top)
// Accepts exception requests, escalates them against the record, and
// registers the result one cycle after acceptance. Raises a sticky
// shutdown on triple fault. Assumes the consumer holds out_ready steady
// for as long as it wants to stall.
module exc_escalator
    import exc_esc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int ERR_W = 32,
    parameter int IP_W  = 32,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VEC_W-1:0] req_vector,
    input  logic             req_swint,
    input  logic [ERR_W-1:0] req_errcode,
    input  logic [IP_W-1:0]  req_ip,
    input  logic [LEN_W-1:0] req_ilen,
    input  logic             done,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_vector,
    output logic [ERR_W-1:0] out_errcode,
    output logic [IP_W-1:0]  out_next_ip,
    output logic             out_swint,
    output logic             shutdown
);

    localparam logic [VEC_W-1:0] V_DF = VEC_W'(VEC_DOUBLE_FAULT);

    logic             accept;
    logic             prev_valid;
    logic [VEC_W-1:0] prev_vec;
    logic             eff_prev_valid;
    logic             triple;
    logic             promote;
    logic [VEC_W-1:0] fin_vec;
    logic [ERR_W-1:0] fin_err;
    logic             store_en;
    logic [IP_W-1:0]  next_ip;

    // Purpose: handshake on the request side
    always_comb begin
        req_ready = !shutdown && (!out_valid || out_ready);
        accept    = req_valid && req_ready;
    end

    // Purpose: a same-cycle delivery-complete clear is applied first
    always_comb begin
        eff_prev_valid = prev_valid && !done;
    end

    exc_escalate_core #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_core (
        .prev_valid (eff_prev_valid),
        .prev_vec   (prev_vec),
        .new_vec    (req_vector),
        .new_err    (req_errcode),
        .swint      (req_swint),
        .triple     (triple),
        .promote    (promote),
        .fin_vec    (fin_vec),
        .fin_err    (fin_err),
        .store_en   (store_en)
    );

    exc_prev_track #(.VEC_W(VEC_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (done),
        .load       (accept && store_en),
        .load_vec   (fin_vec),
        .prev_valid (prev_valid),
        .prev_vec   (prev_vec)
    );

    // Purpose: return address, with the length added for software interrupts
    always_comb begin
        next_ip = req_swint ? (req_ip + IP_W'(req_ilen)) : req_ip;
    end

    // Purpose: output register with valid/ready hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_vector  <= '0;
            out_errcode <= '0;
            out_next_ip <= '0;
            out_swint   <= 1'b0;
        end else if (accept && !triple) begin
            out_valid   <= 1'b1;
            out_vector  <= fin_vec;
            out_errcode <= fin_err;
            out_next_ip <= next_ip;
            out_swint   <= req_swint;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end

    // Purpose: sticky triple-fault shutdown request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shutdown <= 1'b0;
        end else if (accept && triple) begin
            shutdown <= 1'b1;
        end
    end

    a_r5_shutdown_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> shutdown);

    a_r5_no_ready_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> !req_ready);

    a_r5_triple_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && triple) |=> (shutdown && !out_valid));

    a_r9_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !triple) |=> out_valid);

    a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vector) &&
                                       $stable(out_errcode) && $stable(out_next_ip)));

    a_r2_promote_df_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && promote) |=> (out_vector == V_DF && out_errcode == '0));

    a_r7_swint_no_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_swint) |=> (!shutdown && out_swint));

endmodule

// File: tb/tb_exc_escalator.sv
module tb_exc_escalator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_vector = '0;
    logic        req_swint = 1'b0;
    logic [31:0] req_errcode = '0;
    logic [31:0] req_ip = '0;
    logic [3:0]  req_ilen = '0;
    logic        done = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_vector;
    logic [31:0] out_errcode;
    logic [31:0] out_next_ip;
    logic        out_swint;
    logic        shutdown;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    exc_escalator dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vector(req_vector), .req_swint(req_swint),
        .req_errcode(req_errcode), .req_ip(req_ip), .req_ilen(req_ilen),
        .done(done),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_vector(out_vector), .out_errcode(out_errcode),
        .out_next_ip(out_next_ip), .out_swint(out_swint),
        .shutdown(shutdown)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int cls_of(input int v);
        if (v == 0 || (v >= 10 && v <= 13)) return 1;
        if (v == 14) return 2;
        if (v == 8) return 3;
        return 0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; done = 1'b0; out_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one request for one cycle, sample at the following negedge
    task automatic send(input logic [7:0] v, input logic sw, input logic [31:0] e,
                        input logic [31:0] ip, input logic [3:0] ln, input logic dn);
        @(negedge clk);
        req_valid = 1'b1; req_vector = v; req_swint = sw; req_errcode = e;
        req_ip = ip; req_ilen = ln; done = dn;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R10: reset state
        do_reset();
        chk("R10 out_valid after reset", 64'(out_valid), 64'd0);
        chk("R10 shutdown after reset", 64'(shutdown), 64'd0);
        chk("R10 req_ready after reset", 64'(req_ready), 64'd1);

        // R1-R6 sweep: ordered pair of vectors 0..31
        for (int p = 0; p < 32; p++) begin
            for (int n = 0; n < 32; n++) begin
                int pc, nc, exp_v;
                logic [31:0] ep, en, exp_e;
                logic exp_sd;
                do_reset();
                ep = 32'hA000_0000 | 32'(p);
                en = 32'hB000_0100 | 32'(n);
                send(8'(p), 1'b0, ep, 32'h1000, 4'd3, 1'b0);
                // R4: empty record passes first vector
                chk("R4 first vector", 64'(out_vector), 64'(p));
                chk("R4 first errcode", 64'(out_errcode), 64'(ep));
                chk("R9 first valid", 64'(out_valid), 64'd1);
                chk("R7 next ip non-swint", 64'(out_next_ip), 64'h1000);
                pc = cls_of(p); nc = cls_of(n);
                exp_sd = (pc == 3);
                if ((pc == 1 && nc == 1) || (pc == 2 && (nc == 1 || nc == 2))) begin
                    exp_v = 8; exp_e = 32'd0;       // R2 / R3
                end else begin
                    exp_v = n; exp_e = en;          // R4 (R6: benign first is not kept)
                end
                send(8'(n), 1'b0, en, 32'h2000, 4'd3, 1'b0);
                chk("R5 shutdown", 64'(shutdown), 64'(exp_sd));
                if (exp_sd) begin
                    chk("R5 no result on triple", 64'(out_valid), 64'd0);
                    chk("R5 ready low", 64'(req_ready), 64'd0);
                end else begin
                    chk("R2/R3/R4 vector", 64'(out_vector), 64'(exp_v));
                    chk("R2/R3/R4 errcode", 64'(out_errcode), 64'(exp_e));
                end
            end
        end

        // R5: sticky shutdown over several cycles
        do_reset();
        send(8'd8, 1'b0, 32'h0, 32'h0, 4'd0, 1'b0);
        send(8'd3, 1'b0, 32'h0, 32'h0, 4'd0, 1'b0);
        repeat (4) @(negedge clk);
        chk("R5 shutdown sticky", 64'(shutdown), 64'd1);
        chk("R5 ready stays low", 64'(req_ready), 64'd0);

        // R6: benign after contributory leaves record contributory
        do_reset();
        send(8'd13, 1'b0, 32'h5, 32'h0, 4'd0, 1'b0);
        send(8'd33, 1'b0, 32'h7, 32'h0, 4'd0, 1'b0);
        chk("R6 benign passes", 64'(out_vector), 64'd33);
        send(8'd11, 1'b0, 32'h9, 32'h0, 4'd0, 1'b0);
        chk("R6 record kept contrib", 64'(out_vector), 64'd8);
        chk("R6 promoted err zero", 64'(out_errcode), 64'd0);
        // promoted DF is now stored: next exception shuts down
        send(8'd2, 1'b0, 32'h0, 32'h0, 4'd0, 1'b0);
        chk("R6 stored DF leads to shutdown", 64'(shutdown), 64'd1);

        // R7: software interrupt bypass
        do_reset();
        send(8'd8, 1'b0, 32'h0, 32'h0, 4'd0, 1'b0);
        send(8'd13, 1'b1, 32'h44, 32'h3000, 4'd2, 1'b0);
        chk("R7 swint no shutdown", 64'(shutdown), 64'd0);
        chk("R7 swint vector", 64'(out_vector), 64'd13);
        chk("R7 swint errcode", 64'(out_errcode), 64'h44);
        chk("R7 swint next ip", 64'(out_next_ip), 64'h3002);
        chk("R7 swint flag", 64'(out_swint), 64'd1);
        send(8'd33, 1'b0, 32'h0, 32'h0, 4'd0, 1'b0);
        chk("R7 record untouched by swint", 64'(shutdown), 64'd1);

        // R8: done alone empties record
        do_reset();
        send(8'd12, 1'b0, 32'h1, 32'h0, 4'd0, 1'b0);
        @(negedge clk); done = 1'b1;
        @(negedge clk); done = 1'b0;
        send(8'd10, 1'b0, 32'h22, 32'h0, 4'd0, 1'b0);
        chk("R8 done clears record", 64'(out_vector), 64'd10);
        chk("R8 errcode kept", 64'(out_errcode), 64'h22);

        // R8: done and a raise in the same cycle
        do_reset();
        send(8'd13, 1'b0, 32'h1, 32'h0, 4'd0, 1'b0);
        send(8'd10, 1'b0, 32'h66, 32'h0, 4'd0, 1'b1);
        chk("R8 same-cycle clear first", 64'(out_vector), 64'd10);
        chk("R8 same-cycle errcode", 64'(out_errcode), 64'h66);
        send(8'd11, 1'b0, 32'h77, 32'h0, 4'd0, 1'b0);
        chk("R8 same-cycle update kept", 64'(out_vector), 64'd8);

        // R9: stall holds result and blocks requests
        do_reset();
        out_ready = 1'b0;
        send(8'd33, 1'b0, 32'hCAFE, 32'h40, 4'd0, 1'b0);
        chk("R9 valid one cycle after accept", 64'(out_valid), 64'd1);
        chk("R9 ready low while stalled", 64'(req_ready), 64'd0);
        req_valid = 1'b1; req_vector = 8'd40; req_errcode = 32'h1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        chk("R9 held vector", 64'(out_vector), 64'd33);
        chk("R9 held errcode", 64'(out_errcode), 64'hCAFE);
        chk("R9 held valid", 64'(out_valid), 64'd1);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R9 drained", 64'(out_valid), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule